// File: doc/BRIEF.md
# Continuous Serial Memory Streamer

This block holds a small byte array and plays its contents out, without pause, as a serial bit stream on a single data line. It needs no request from any bus master. All of its state advances on rising edges of a dedicated stream clock. The data line is modelled as a tristate pin: a drive value plus an output enable. A surrounding mode controller decides whether streaming is allowed by driving an enable input.

Before anything is sent, the block goes through a synchronization phase of nine enabled clock edges, and the line stays released for that whole phase. After it, each byte goes out as a nine-slot frame. The eight data bits come first, most significant bit first. The ninth slot is a null slot, and the line is released during it. Bytes are taken in rising address order, and after the last location the pointer wraps to the first one.

The array is filled through a synchronous write port. That port only takes effect while streaming is disabled. Dropping the enable freezes the stream at its current position. Raising it again continues from that same bit, and the synchronization phase is not repeated.

Top module: `serial_image_streamer`

## Requirements
- R1: While reset is asserted, and right after it is released, the output enable is low and the read pointer is at address 0.
- R2: During the first nine rising clock edges taken with the enable high after reset, the output enable stays low.
- R3: The tenth enabled rising edge makes the block drive bit 7 (the most significant bit) of address 0, with the output enable high.
- R4: Every further enabled rising edge moves the stream on by exactly one slot. Slots 0 to 7 of a frame carry bits 7 down to 0 of the current byte, with the output enable high.
- R5: Slot 8 of each frame is the null slot, and the output enable is low for it.
- R6: After the null slot of a byte, the next byte comes from the next higher address. After address 127 the stream continues at address 0.
- R7: While the enable is low, the output enable is low and the synchronization count, slot and address all hold. When the enable returns, the held bit is shown again before the next edge, and no new synchronization phase takes place.
- R8: A write strobe on a rising edge while the enable is low stores the data byte at the given address. That byte is streamed when its address next comes round.
- R9: A write strobe on a rising edge while the enable is high has no effect on the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Stream clock; one slot per enabled rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Streaming enable from the mode controller |
| wr_en_i | input | 1 | Write strobe of the preload port |
| wr_addr_i | input | 7 | Preload write address |
| wr_data_i | input | 8 | Preload write data |
| sd_o | output | 1 | Drive value of the serial data line |
| sd_oe_o | output | 1 | Output enable of the serial data line (0 = released) |

## Verification
Two functions of this block can fall in the same cycle: a preload write, and the streamer reading the array. The bench provokes this by pulsing the write strobe in a cycle where the enable is high. It then streams a full lap and requires the byte at that address to come out with its old value. Stream freezing and preload writing can also share a cycle. The bench therefore writes one location during a mid-byte pause, and checks two things: the held bit reappears unchanged on resume, and the new byte shows up on the following lap.

// File: rtl/sis_pkg.sv
package sis_pkg;

  // Index of the data bit carried by a slot, most significant bit first.
  function automatic int unsigned bit_index(int unsigned width, int unsigned slot);
    return width - 1 - slot;
  endfunction

  // The slot after the last data bit is the null slot.
  function automatic logic is_null_slot(int unsigned width, int unsigned slot);
    return slot == width;
  endfunction

  // Ascending address with wrap at the array depth.
  function automatic int unsigned next_addr(int unsigned depth, int unsigned addr);
    return (addr + 1) % depth;
  endfunction

  // The synchronization phase is finished once this many edges are counted.
  function automatic logic sync_reached(int unsigned edges, int unsigned cnt);
    return cnt >= edges;
  endfunction

endpackage

// File: rtl/sis_sync_gate.sv
module sis_sync_gate #(
  parameter int unsigned SYNC_EDGES = 9,
  localparam int unsigned CNT_W = $clog2(SYNC_EDGES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic             synced_o,
  output logic [CNT_W-1:0] cnt_o
);
  import sis_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             count_edge;

  assign count_edge = en_i && !done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (count_edge) begin
      if (sync_reached(SYNC_EDGES, int'(cnt_q))) begin
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign synced_o = done_q;
  assign cnt_o    = cnt_q;

  // R7: the synchronization count holds while disabled
  p_sync_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q) && $stable(done_q));

  // R2: completion never comes before the full edge count
  p_sync_full_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> cnt_q == CNT_W'(SYNC_EDGES));

endmodule

// File: rtl/sis_frame_seq.sv
module sis_frame_seq #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned SLOT_W = $clog2(WIDTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  output logic [AW-1:0]     addr_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              null_slot_o
);
  import sis_pkg::*;

  logic [AW-1:0]     addr_q;
  logic [SLOT_W-1:0] slot_q;
  logic              frame_end;

  assign frame_end = is_null_slot(WIDTH, int'(slot_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      slot_q <= '0;
    end else if (step_i) begin
      if (frame_end) begin
        slot_q <= '0;
        addr_q <= AW'(next_addr(DEPTH, int'(addr_q)));
      end else begin
        slot_q <= slot_q + SLOT_W'(1);
      end
    end
  end

  assign addr_o      = addr_q;
  assign slot_o      = slot_q;
  assign null_slot_o = frame_end;

  // R4: a data slot is followed by the next slot of the same byte
  p_slot_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !frame_end) |=> (slot_q == $past(slot_q) + SLOT_W'(1)) && $stable(addr_q));

  // R6: the last byte is followed by the first one
  p_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && frame_end && addr_q == AW'(DEPTH - 1)) |=> addr_q == '0 && slot_q == '0);

  // R7: position holds without a step
  p_pos_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(addr_q) && $stable(slot_q));

endmodule

// File: rtl/sis_byte_store.sv
module sis_byte_store #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [WIDTH-1:0] rd_data_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic             wr_fire;

  assign wr_fire = wr_en_i && !en_i;

  always_ff @(posedge clk_i) begin
    if (wr_fire) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  // R8: a write while disabled lands at its address
  p_write_lands_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !en_i) |=> mem_q[$past(wr_addr_i)] == $past(wr_data_i));

  // R9: a write while streaming leaves the array untouched
  p_write_blocked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && en_i) |=> mem_q[$past(wr_addr_i)] == $past(mem_q[wr_addr_i]));

endmodule

// File: rtl/serial_image_streamer.sv
module serial_image_streamer #(
  parameter int unsigned DEPTH      = 128,
  parameter int unsigned WIDTH      = 8,
  parameter int unsigned SYNC_EDGES = 9,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned SLOT_W = $clog2(WIDTH + 1),
  localparam int unsigned CNT_W  = $clog2(SYNC_EDGES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic             sd_o,
  output logic             sd_oe_o
);
  import sis_pkg::*;

  logic              synced;
  logic [CNT_W-1:0]  sync_cnt;
  logic              step;
  logic [AW-1:0]     cur_addr;
  logic [SLOT_W-1:0] cur_slot;
  logic              null_slot;
  logic [WIDTH-1:0]  cur_byte;
  logic              cur_bit;

  sis_sync_gate #(.SYNC_EDGES(SYNC_EDGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .synced_o (synced),
    .cnt_o    (sync_cnt)
  );

  // The stream only moves once synchronization is complete.
  assign step = en_i && synced;

  sis_frame_seq #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (step),
    .addr_o      (cur_addr),
    .slot_o      (cur_slot),
    .null_slot_o (null_slot)
  );

  sis_byte_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (cur_addr),
    .rd_data_o (cur_byte)
  );

  always_comb begin
    cur_bit = 1'b0;
    if (!null_slot) begin
      cur_bit = cur_byte[bit_index(WIDTH, int'(cur_slot))];
    end
  end

  assign sd_oe_o = en_i && synced && !null_slot;
  assign sd_o    = sd_oe_o ? cur_bit : 1'b0;

  // R1: nothing is driven under reset, and the pointer is at the origin
  always @(negedge clk_i) begin
    if (rst_ni === 1'b0) begin
      a_reset_quiet_r1: assert (!sd_oe_o && cur_addr == '0 && cur_slot == '0);
    end
  end

  // R2: the line is released before synchronization completes
  p_quiet_sync_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !synced |-> !sd_oe_o);

  // R3: the first driven slot is bit 7 of address 0
  p_first_bit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(synced) |-> cur_addr == '0 && cur_slot == '0);

  // R5: the null slot releases the line
  p_null_released_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    null_slot |-> !sd_oe_o);

  // R7: disabled means released
  p_idle_released_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !sd_oe_o);

endmodule

// File: tb/serial_image_streamer_bench.sv
module serial_image_streamer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       wr_en = 1'b0;
  logic [6:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       sd, sd_oe;

  logic [7:0] model [128];
  int k = 0;
  int checks = 0;
  int errors = 0;
  int watch_a = -1;
  string watch_tag = "";

  always #4 clk = ~clk;

  serial_image_streamer u_serial_image_streamer (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .sd_o(sd), .sd_oe_o(sd_oe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (k=%0d)", tag, act, exp, k);
    end
  endtask

  // Compare the outputs with the position counted from enabled edges.
  task automatic judge();
    int p, slot, byt;
    string tag;
    if (!en) begin
      chk("R7 released while disabled", int'(sd_oe), 0);
    end else if (k < 10) begin
      chk("R2 released during sync", int'(sd_oe), 0);
    end else begin
      p = k - 10;
      slot = p % 9;
      byt = (p / 9) % 128;
      if (k == 10) tag = "R3 first bit";
      else if (slot == 8) tag = "R5 null slot";
      else if (p / 9 >= 128 && byt == 0) tag = "R6 wrapped byte";
      else tag = "R4 data slot";
      if (byt == watch_a) tag = watch_tag;
      chk(tag, int'(sd_oe), (slot == 8) ? 0 : 1);
      if (slot < 8) chk(tag, int'(sd), int'(model[byt][7 - slot]));
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (en) k++;
    @(negedge clk);
    judge();
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 enable low in reset", int'(sd_oe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 enable low after reset", int'(sd_oe), 0);

    // Preload while disabled (R8).
    for (int a = 0; a < 128; a++) begin
      @(negedge clk);
      wr_en = 1'b1;
      wr_addr = 7'(a);
      wr_data = 8'((a * 37 + 5) ^ (a >> 1));
      model[a] = 8'((a * 37 + 5) ^ (a >> 1));
    end
    @(negedge clk);
    wr_en = 1'b0;
    chk("R1 still released after preload", int'(sd_oe), 0);

    // Sync phase with a pause in the middle (R2, R7).
    en = 1'b1;
    steps(4);
    en = 1'b0;
    steps(3);
    en = 1'b1;
    steps(12);

    // Stream past the wrap (R4, R5, R6).
    steps(128 * 9 + 20);

    // Write while streaming must be ignored (R9).
    wr_en = 1'b1;
    wr_addr = 7'd5;
    wr_data = ~model[5];
    step();
    wr_en = 1'b0;
    watch_a = 5;
    watch_tag = "R9 byte kept after blocked write";
    steps(128 * 9);

    // Pause mid-byte, write while disabled, resume at the held bit (R7, R8).
    steps(3);
    en = 1'b0;
    step();
    wr_en = 1'b1;
    wr_addr = 7'd9;
    wr_data = 8'hA6;
    step();
    wr_en = 1'b0;
    model[9] = 8'hA6;
    steps(2);
    en = 1'b1;
    #1;
    begin
      int p = k - 10;
      chk("R7 held slot resumes oe", int'(sd_oe), (p % 9 == 8) ? 0 : 1);
      if (p % 9 < 8) chk("R7 held bit resumes", int'(sd), int'(model[(p / 9) % 128][7 - p % 9]));
    end
    watch_a = 9;
    watch_tag = "R8 written byte streamed";
    steps(128 * 9 + 9);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule